// File: doc/BRIEF.md
# Two-Mode Page Map Translator

This block turns a 16-bit virtual byte address into an 18-bit physical address, working in either of two privilege modes: Exec or User. It keeps its own copy of the current mode and two map base registers, one per mode. Each base register holds the physical page number of the page that holds that mode's map. The virtual space has 128 pages of 512 bytes. For most pages the block works out where the page's one-word map entry sits in memory and reads it through a simple memory read port. It then builds the physical address from the entry's page-number field and the byte offset. The whole fetched entry word is handed on, so that a downstream protection checker can see the key bits.

Two special cases skip or redirect the lookup. Exec page 0 needs no lookup: it maps straight onto the page named by the Exec base register, and that page also holds the Exec map in its upper half. With per-process Exec mapping switched on, the upper half of the Exec space takes its entries from the upper half of the page that holds the current User map. A new User map therefore also brings its own set of per-process Exec entries. Any page number beyond installed memory (496 pages) raises a bus-error flag on the response.

The block serves one translation at a time. A request is taken when `req_ready` is high, and the result comes back as a one-cycle `rsp_valid` pulse.

Top module: `pmt_top`

## Requirements
- R1: After reset the mode is Exec, both base registers are 0, per-process mapping is off, `req_ready` is 1, and `mem_rd` and `rsp_valid` are 0.
- R2: In User mode (mode bit 0), a request for virtual page v (address bits 15:9) reads the word at physical address user_base*512 + 2*v. The response carries that word on `rsp_entry` and `rsp_paddr` = {word[8:0], vaddr[8:0]}, with `rsp_direct` = 0.
- R3: In Exec mode (mode bit 1), for a page v other than 0 that is not redirected by R5, the entry read is at exec_base*512 + 256 + 2*v.
- R4: In Exec mode, page 0 issues no memory read. `rsp_valid` rises in the cycle after acceptance, with `rsp_paddr` = {exec_base, vaddr[8:0]}, `rsp_direct` = 1 and `rsp_entry` = 0.
- R5: In Exec mode with per-process mapping on, pages 64 to 127 read their entry at user_base*512 + 256 + 2*v. With the control bit off, these pages use the Exec map as in R3.
- R6: If the map page chosen for a lookup is 496 or more, no read is issued. The response arrives in the cycle after acceptance with `rsp_buserr` = 1, `rsp_paddr` = 0 and `rsp_entry` = 0. For R4, an Exec base of 496 or more sets `rsp_buserr` but leaves `rsp_paddr` as stated in R4.
- R7: A fetched entry whose bits 8:0 are 496 or more gives `rsp_buserr` = 1, with `rsp_paddr` and `rsp_entry` still formed as in R2. A value below 496 gives `rsp_buserr` = 0.
- R8: Once a read is issued, `mem_rd` stays high and `mem_addr` stays unchanged until the cycle where `mem_rvalid` is sampled high. The response appears in the following cycle, and `req_ready` is 0 while the read is outstanding.
- R9: A register write takes effect from the next cycle. `reg_sel` 0 loads the Exec base and 1 loads the User base, each from `reg_wdata[8:0]`. `reg_sel` 2 loads the mode from `reg_wdata[0]`, and 3 loads the per-process enable from `reg_wdata[0]`. A write made while a read is outstanding does not change that translation.
- R10: A request presented while `req_ready` is 0 is ignored: it causes no read and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 Exec base, 1 User base, 2 mode, 3 per-process enable) |
| reg_wdata | input | 9 | Register write data |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 16 | Virtual byte address |
| req_ready | output | 1 | Block can accept a request |
| mem_rd | output | 1 | Map entry read request, held until data returns |
| mem_addr | output | 18 | Physical byte address of the map entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Map entry word |
| rsp_valid | output | 1 | Result valid for one cycle |
| rsp_paddr | output | 18 | Physical byte address |
| rsp_entry | output | 16 | Fetched entry word (0 when none was fetched) |
| rsp_direct | output | 1 | Result came from the Exec page 0 shortcut |
| rsp_buserr | output | 1 | A page number lies beyond installed memory |

## Verification
The bench builds the block with its default limits: 496 installed pages and per-process mapping starting at page 64. With these values it can reach both sides of each limit. It uses map bases and fetched page numbers just below and just above 495, and Exec pages 63, 64 and 127 with the enable bit in either state. Memory latency is varied from zero to three wait cycles, so that both the hold of the read request and the window for ignored requests are exercised.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int OFF_W  = 9;
  localparam int VPN_W  = 7;
  localparam int PPN_W  = 9;
  localparam int VA_W   = VPN_W + OFF_W;
  localparam int PA_W   = PPN_W + OFF_W;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    SEL_EXEC_BASE = 2'd0,
    SEL_USER_BASE = 2'd1,
    SEL_MODE      = 2'd2,
    SEL_EPP       = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1
  } walk_state_e;

  // Join a page number and a byte offset into a physical byte address.
  function automatic logic [PA_W-1:0] compose_pa(input logic [PPN_W-1:0] ppn,
                                                 input logic [OFF_W-1:0] off);
    return {ppn, off};
  endfunction

  // Byte offset of a one-word entry inside a map page; upper picks the high half.
  function automatic logic [OFF_W-1:0] entry_offset(input logic upper,
                                                    input logic [VPN_W-1:0] vpn);
    return {upper, vpn, 1'b0};
  endfunction

  // True when a page number lies inside installed memory.
  function automatic logic ppn_ok(input logic [PPN_W-1:0] ppn, input int unsigned limit);
    return 32'(ppn) < limit;
  endfunction
endpackage

// File: rtl/pmt_ctl_regs.sv
module pmt_ctl_regs
  import pmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [PPN_W-1:0] wdata,
  output logic [PPN_W-1:0] exec_base,
  output logic [PPN_W-1:0] user_base,
  output logic             mode_exec,
  output logic             epp_en
);
  reg_sel_e sel_e;
  assign sel_e = reg_sel_e'(sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exec_base <= '0;
      user_base <= '0;
      mode_exec <= 1'b1;
      epp_en    <= 1'b0;
    end else if (we) begin
      case (sel_e)
        SEL_EXEC_BASE: exec_base <= wdata;
        SEL_USER_BASE: user_base <= wdata;
        SEL_MODE:      mode_exec <= wdata[0];
        SEL_EPP:       epp_en    <= wdata[0];
        default: ;
      endcase
    end
  end

  // R9: a mode write is visible on the next cycle
  p_mode_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == 2'd2) |=> (mode_exec == $past(wdata[0])));
  // R9: a register that is not written keeps its value
  p_base_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!we) |=> $stable(exec_base) && $stable(user_base));
endmodule

// File: rtl/pmt_route.sv
module pmt_route
  import pmt_pkg::*;
#(
  parameter int unsigned PHYS_PAGES = 496,
  parameter int unsigned EPP_FIRST  = 64
) (
  input  logic             mode_exec,
  input  logic             epp_en,
  input  logic [PPN_W-1:0] exec_base,
  input  logic [PPN_W-1:0] user_base,
  input  logic [VPN_W-1:0] vpn,
  output logic             is_direct,
  output logic             epp_hit,
  output logic [PPN_W-1:0] map_page,
  output logic [OFF_W-1:0] ent_off,
  output logic             base_bad
);
  localparam int unsigned VPAGES = 2 ** VPN_W;

  generate
    if (EPP_FIRST < VPAGES) begin : g_epp
      localparam logic [VPN_W-1:0] EPP_LO = EPP_FIRST[VPN_W-1:0];
      assign epp_hit = mode_exec && epp_en && (vpn >= EPP_LO);
    end else begin : g_no_epp
      assign epp_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    is_direct = mode_exec && (vpn == '0);
    if (!mode_exec || epp_hit) map_page = user_base;
    else                       map_page = exec_base;
    ent_off  = entry_offset(mode_exec, vpn);
    base_bad = !ppn_ok(map_page, PHYS_PAGES);
  end
endmodule

// File: rtl/pmt_walk.sv
module pmt_walk
  import pmt_pkg::*;
#(
  parameter int unsigned PHYS_PAGES = 496
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [OFF_W-1:0]  req_off,
  input  logic              is_direct,
  input  logic [PPN_W-1:0]  direct_ppn,
  input  logic [PPN_W-1:0]  map_page,
  input  logic [OFF_W-1:0]  ent_off,
  input  logic              base_bad,
  output logic              req_ready,
  output logic              mem_rd,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [WORD_W-1:0] rsp_entry,
  output logic              rsp_direct,
  output logic              rsp_buserr
);
  walk_state_e      state;
  logic [OFF_W-1:0] off_q;
  logic [PA_W-1:0]  addr_q;

  // Named events for the checks below.
  logic accept, accept_direct, accept_bad, accept_read, finish;
  logic [PPN_W-1:0] fetched_ppn;

  assign req_ready     = (state == ST_IDLE);
  assign accept        = req_ready && req_valid;
  assign accept_direct = accept && is_direct;
  assign accept_bad    = accept && !is_direct && base_bad;
  assign accept_read   = accept && !is_direct && !base_bad;
  assign finish        = (state == ST_READ) && mem_rvalid;
  assign fetched_ppn   = mem_rdata[PPN_W-1:0];
  assign mem_rd        = (state == ST_READ);
  assign mem_addr      = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      off_q      <= '0;
      addr_q     <= '0;
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_entry  <= '0;
      rsp_direct <= 1'b0;
      rsp_buserr <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept_direct) begin
        rsp_valid  <= 1'b1;
        rsp_paddr  <= compose_pa(direct_ppn, req_off);
        rsp_entry  <= '0;
        rsp_direct <= 1'b1;
        rsp_buserr <= !ppn_ok(direct_ppn, PHYS_PAGES);
      end else if (accept_bad) begin
        rsp_valid  <= 1'b1;
        rsp_paddr  <= '0;
        rsp_entry  <= '0;
        rsp_direct <= 1'b0;
        rsp_buserr <= 1'b1;
      end else if (accept_read) begin
        state  <= ST_READ;
        off_q  <= req_off;
        addr_q <= compose_pa(map_page, ent_off);
      end else if (finish) begin
        state      <= ST_IDLE;
        rsp_valid  <= 1'b1;
        rsp_paddr  <= compose_pa(fetched_ppn, off_q);
        rsp_entry  <= mem_rdata;
        rsp_direct <= 1'b0;
        rsp_buserr <= !ppn_ok(fetched_ppn, PHYS_PAGES);
      end
    end
  end

  // R8: an outstanding read holds its request and address until data returns
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_rvalid) |=> (mem_rd && $stable(mem_addr)));
  // R8: the response follows the data beat by one cycle
  p_rsp_after_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_rvalid) |=> (rsp_valid && !mem_rd && !rsp_direct));
  // R4: the page 0 shortcut never touches memory
  p_direct_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_direct |=> (!mem_rd && rsp_valid && rsp_direct));
  // R6: a bad map base gives an immediate bus error without a read
  p_bad_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_bad |=> (!mem_rd && rsp_valid && rsp_buserr));
  // R7: a clean looked-up result always points inside installed memory
  p_result_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_buserr && !rsp_direct) |->
      (32'(rsp_paddr[PA_W-1:OFF_W]) < PHYS_PAGES));
  // R10: while a read is outstanding nothing new is taken
  p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_rvalid && req_valid) |=> (mem_rd && !rsp_valid));
endmodule

// File: rtl/pmt_top.sv
module pmt_top
  import pmt_pkg::*;
#(
  parameter int unsigned PHYS_PAGES = 496,
  parameter int unsigned EPP_FIRST  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [PPN_W-1:0]  reg_wdata,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              req_ready,
  output logic              mem_rd,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [WORD_W-1:0] rsp_entry,
  output logic              rsp_direct,
  output logic              rsp_buserr
);
  logic [PPN_W-1:0] exec_base, user_base, map_page;
  logic             mode_exec, epp_en, is_direct, epp_hit, base_bad;
  logic [OFF_W-1:0] ent_off;
  logic [VPN_W-1:0] vpn;
  logic [OFF_W-1:0] off;

  assign vpn = req_vaddr[VA_W-1:OFF_W];
  assign off = req_vaddr[OFF_W-1:0];

  pmt_ctl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .sel       (reg_sel),
    .wdata     (reg_wdata),
    .exec_base (exec_base),
    .user_base (user_base),
    .mode_exec (mode_exec),
    .epp_en    (epp_en)
  );

  pmt_route #(.PHYS_PAGES(PHYS_PAGES), .EPP_FIRST(EPP_FIRST)) u_route (
    .mode_exec (mode_exec),
    .epp_en    (epp_en),
    .exec_base (exec_base),
    .user_base (user_base),
    .vpn       (vpn),
    .is_direct (is_direct),
    .epp_hit   (epp_hit),
    .map_page  (map_page),
    .ent_off   (ent_off),
    .base_bad  (base_bad)
  );

  pmt_walk #(.PHYS_PAGES(PHYS_PAGES)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_off    (off),
    .is_direct  (is_direct),
    .direct_ppn (exec_base),
    .map_page   (map_page),
    .ent_off    (ent_off),
    .base_bad   (base_bad),
    .req_ready  (req_ready),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_paddr  (rsp_paddr),
    .rsp_entry  (rsp_entry),
    .rsp_direct (rsp_direct),
    .rsp_buserr (rsp_buserr)
  );

  // R5: a per-process hit always reads from the User map page, upper half
  p_epp_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && epp_hit && !base_bad) |=>
      (mem_rd && mem_addr == {$past(user_base), 1'b1, $past(vpn), 1'b0}));
  // R2: a User mode lookup reads the lower half of the User map page
  p_user_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !mode_exec && !base_bad) |=>
      (mem_rd && mem_addr[OFF_W-1] == 1'b0));
endmodule

// File: tb/pmt_top_tb.sv
module pmt_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [8:0]  reg_wdata = 9'd0;
  logic        req_valid = 1'b0;
  logic [15:0] req_vaddr = 16'd0;
  logic        req_ready;
  logic        mem_rd;
  logic [17:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = 16'd0;
  logic        rsp_valid;
  logic [17:0] rsp_paddr;
  logic [15:0] rsp_entry;
  logic        rsp_direct;
  logic        rsp_buserr;

  int n_checks = 0;
  int n_fail = 0;
  bit force_bad = 1'b0;

  // Bench view of the control state.
  int unsigned m_eb = 0, m_ub = 0;
  bit m_exec = 1'b1, m_epp = 1'b0;

  always #5 clk = ~clk;

  pmt_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_entry(rsp_entry),
    .rsp_direct(rsp_direct), .rsp_buserr(rsp_buserr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory contents are a fixed scramble of the word address.
  function automatic logic [15:0] mem_word(input logic [17:0] a);
    logic [15:0] w;
    w = (a[15:0] * 16'h6D2B) ^ {a[17:16], 14'h0} ^ 16'h1357;
    if (force_bad) w[8:0] = 9'd500;
    return w;
  endfunction

  // Reference: which map page a lookup uses, or -1 for the page 0 shortcut.
  function automatic longint map_of(input int unsigned vpn);
    if (m_exec && vpn == 0) return -1;
    if (!m_exec) return m_ub;
    if (m_epp && vpn >= 64) return m_ub;
    return m_eb;
  endfunction

  function automatic longint unsigned entry_addr(input int unsigned page, input int unsigned vpn);
    return page * 512 + (m_exec ? 256 : 0) + vpn * 2;
  endfunction

  task automatic wr(input int sel, input int unsigned data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel[1:0]; reg_wdata = data[8:0];
    @(negedge clk);
    reg_we = 1'b0;
    case (sel)
      0: m_eb = data % 512;
      1: m_ub = data % 512;
      2: m_exec = data[0];
      default: m_epp = data[0];
    endcase
  endtask

  // One translation; lat is memory wait cycles, poke writes the User base mid-flight.
  task automatic xlate(input logic [15:0] va, input int lat, input bit poke, input string req);
    longint mp;
    longint unsigned ea, exp_pa, off;
    logic [15:0] word;
    int unsigned vpn;
    vpn = va[15:9];
    off = va[8:0];
    mp = map_of(vpn);
    @(negedge clk);
    chk(req_ready == 1'b1, req, "ready before request", req_ready, 1);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    if (mp < 0) begin
      chk(rsp_valid && !mem_rd, req, "direct response next cycle", {rsp_valid, mem_rd}, 2'b10);
      exp_pa = m_eb * 512 + off;
      chk(rsp_paddr == exp_pa[17:0], req, "direct paddr", rsp_paddr, exp_pa);
      chk(rsp_direct && rsp_entry == 0, req, "direct flag/entry", {rsp_direct, rsp_entry}, 17'h10000);
      chk(rsp_buserr == (m_eb >= 496), "R6", "direct buserr", rsp_buserr, m_eb >= 496);
    end else if (mp >= 496) begin
      chk(rsp_valid && !mem_rd, "R6", "bad base response, no read", {rsp_valid, mem_rd}, 2'b10);
      chk(rsp_buserr && rsp_paddr == 0 && rsp_entry == 0 && !rsp_direct, "R6", "bad base fields",
          {rsp_buserr, rsp_paddr, rsp_entry}, {1'b1, 34'd0});
    end else begin
      ea = entry_addr(mp, vpn);
      chk(mem_rd && !rsp_valid, req, "read issued", {mem_rd, rsp_valid}, 2'b10);
      chk(mem_addr == ea[17:0], req, "entry address", mem_addr, ea);
      for (int i = 0; i < lat; i++) begin
        req_valid = 1'b1; req_vaddr = ~va;
        if (poke && i == 0) begin
          reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 9'd77;
        end
        @(negedge clk);
        reg_we = 1'b0;
        chk(mem_rd && mem_addr == ea[17:0] && !req_ready, "R8", "read held",
            mem_addr, ea);
        chk(!rsp_valid, "R10", "no response while busy", rsp_valid, 0);
      end
      if (poke && lat > 0) m_ub = 77;
      word = mem_word(ea[17:0]);
      mem_rvalid = 1'b1; mem_rdata = word;
      @(negedge clk);
      mem_rvalid = 1'b0; req_valid = 1'b0;
      exp_pa = word[8:0] * 512 + off;
      chk(rsp_valid && !mem_rd && !rsp_direct, "R8", "response after data",
          {rsp_valid, mem_rd, rsp_direct}, 3'b100);
      chk(rsp_paddr == exp_pa[17:0], req, "looked-up paddr", rsp_paddr, exp_pa);
      chk(rsp_entry == word, req, "entry word", rsp_entry, word);
      chk(rsp_buserr == (word[8:0] >= 496), "R7", "entry buserr", rsp_buserr, word[8:0] >= 496);
    end
    @(negedge clk);
    chk(!rsp_valid && !mem_rd, "R10", "no stray activity", {rsp_valid, mem_rd}, 0);
  endtask

  initial begin
    #(10 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !mem_rd && !rsp_valid, "R1", "idle after reset",
        {req_ready, mem_rd, rsp_valid}, 3'b100);
    xlate(16'h01FF, 0, 0, "R1");              // Exec page 0 through base 0
    xlate(16'h0A10, 1, 0, "R3");              // Exec page 5, base 0
    wr(0, 9'd300); wr(1, 9'd12);
    xlate(16'h0123, 0, 0, "R4");
    xlate(16'h0600, 2, 0, "R3");
    wr(2, 0);
    xlate(16'h0A55, 0, 0, "R2");
    xlate(16'hFFFF, 3, 0, "R2");
    xlate(16'h0000, 1, 0, "R2");              // User page 0 still looks up
    wr(2, 1); wr(3, 1);
    xlate(16'h8000, 0, 0, "R5");              // page 64
    xlate(16'hFE01, 1, 0, "R5");              // page 127
    xlate(16'h7E01, 1, 0, "R5");              // page 63 stays on Exec map
    wr(3, 0);
    xlate(16'hC8AA, 0, 0, "R5");              // enable off
    wr(0, 9'd500);
    xlate(16'h0042, 0, 0, "R6");              // direct, bad base
    xlate(16'h0242, 0, 0, "R6");              // lookup, bad base
    wr(0, 9'd495);
    xlate(16'h0442, 0, 0, "R3");
    wr(2, 0); wr(1, 9'd496);
    xlate(16'h3000, 0, 0, "R6");
    wr(1, 9'd20);
    force_bad = 1'b1;
    xlate(16'h1234, 1, 0, "R7");
    force_bad = 1'b0;
    xlate(16'h2345, 2, 1, "R9");              // User base written mid-flight
    chk(m_ub == 77, "R9", "shadow updated", m_ub, 77);
    xlate(16'h2345, 0, 0, "R9");              // new base now in use
    for (int k = 0; k < 200; k++) begin
      int unsigned r;
      r = $urandom % 8;
      if (r == 0) wr(0, $urandom % 512);
      if (r == 1) wr(1, $urandom % 512);
      if (r == 2) wr(2, $urandom % 2);
      if (r == 3) wr(3, $urandom % 2);
      force_bad = ($urandom % 16) == 0;
      xlate(($urandom % 4 == 0) ? 16'($urandom % 512) : 16'($urandom), $urandom % 4, 0, "R2");
      force_bad = 1'b0;
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule